// File: doc/BRIEF.md
# Serial-Programmed Output Driver Controller

The block is a 16-bit serial slave. It keeps a small set of configuration words and drives twelve output enables from them. Outputs 0 to 3 are high-side channels and outputs 4 to 11 are low-side channels. Each frame carries three fields: a watchdog toggle bit, a 3-bit address and 12 data bits. Three of the addresses are used to work out the outputs:

- the message word holds the requested state of each output;
- the direct-enable word chooses which outputs listen to an external direct-input pin;
- the function word chooses, for each output, whether the message bit is ANDed or ORed with that pin.

Each high-side channel has its own direct-input pin. All low-side channels share one pin.

The remaining configuration words have no effect on the outputs. They are stored and driven out on ports for the neighbouring driver logic:

- the watchdog timeout select and the high-side configuration;
- the open-load configuration;
- the current-limit configuration.

For every committed frame the block gives a one-cycle pulse and the captured toggle bit. An external watchdog uses these to check that the bit alternates. The serial pins and the direct-input pins are all brought into the system clock domain through two-flop synchronizers.

Top module: `outctl_spi`

## Requirements
- R1: The serial port uses mode 0 (data sampled on the rising edge of sclk_i while cs_ni is low), MSB first. The frame is word[15] = toggle bit, word[14:12] = address, word[11:0] = data. A frame is committed when cs_ni rises after exactly 16 sclk_i rising edges.
- R2: A frame with any other number of sclk_i edges (for example 15 or 17) is discarded. It changes no output and gives no frame pulse.
- R3: Address 3'b000 (word[14:12]) stores the message word: data[3:0] drives hs_o[3:0] and data[11:4] drives ls_o[7:0], one bit per output, when direct control is off.
- R4: After reset all outputs and configuration ports are 0, and direct control is off for all twelve outputs: the direct-enable word resets to all ones.
- R5: Address 3'b100 writes the direct-enable word, where a 0 bit places that output under direct control. Address 3'b010 writes the function word. A 1 in the function word gives output = message AND pin.
- R6: A 0 in the function word gives output = message OR pin, for an output under direct control.
- R7: An output whose direct-enable bit is 1 equals its message bit whatever its pin does.
- R8: Output i < 4 pairs with dhs_i[i]. Every output 4 to 11 pairs with the shared dls_i.
- R9: Address 3'b110 loads wd_sel_o from data[5:4] and hs_cfg_o from data[3:0]. Data[11:6] are ignored.
- R10: Address 3'b001 loads ol_cfg_o and address 3'b101 loads ilim_cfg_o, each with the full 12 data bits. Addresses 3'b011 and 3'b111 change nothing.
- R11: frame_o pulses high for exactly one cycle per committed frame. wd_bit_o then holds word[15] of that frame.
- R12: After a change on dhs_i or dls_i, outputs hold their old value for two clocks and show the new value after the third rising edge. Outputs never change unless a configuration word or a synchronized pin has changed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sclk_i | input | 1 | Serial clock |
| cs_ni | input | 1 | Serial chip select, active low |
| mosi_i | input | 1 | Serial data in |
| dhs_i | input | 4 | Direct-input pins, one per high-side output |
| dls_i | input | 1 | Shared direct-input pin for all low-side outputs |
| hs_o | output | 4 | High-side output enables |
| ls_o | output | 8 | Low-side output enables (channels 4 to 11) |
| wd_sel_o | output | 2 | Watchdog timeout select |
| hs_cfg_o | output | 4 | Per-channel high-side configuration bits |
| ol_cfg_o | output | 12 | Open-load configuration word |
| ilim_cfg_o | output | 12 | Current-limit configuration word |
| frame_o | output | 1 | One-cycle pulse per committed frame |
| wd_bit_o | output | 1 | Toggle bit of the last committed frame |

## Verification
The message word is written with an asymmetric pattern and also with single bits at each end. This separates MSB-first from LSB-first shifting and shows any swap between the high-side and low-side fields. The mixing logic is tried with all channels on direct control under OR and then under AND. Each time the high-side pins carry a non-uniform pattern while the shared low-side pin is flipped, so that a wrong pin pairing or an inverted function select gives a different output. A partial direct-enable mask together with pin toggles shows that channels off direct control ignore their pin. Short and long frames and writes to the two dead addresses show that nothing else is disturbed.

// File: rtl/outctl_pkg.sv
package outctl_pkg;
  parameter int unsigned FRAME_W = 16;
  parameter int unsigned DATA_W  = 12;
  parameter int unsigned ADDR_W  = 3;
  parameter int unsigned N_HS    = 4;
  parameter int unsigned WDS_W   = 2;
  localparam int unsigned N_OUT  = DATA_W;
  localparam int unsigned ADDR_LSB = DATA_W;
  localparam int unsigned TOG_BIT  = FRAME_W - 1;

  // value of word[14:12]
  typedef enum logic [ADDR_W-1:0] {
    ADR_MSG = 3'b000,
    ADR_DIR = 3'b100,
    ADR_FUN = 3'b010,
    ADR_WDC = 3'b110,
    ADR_OLC = 3'b001,
    ADR_ILC = 3'b101,
    ADR_NUL = 3'b011,
    ADR_TST = 3'b111
  } addr_e;

  typedef struct packed {
    logic [DATA_W-1:0] msg;
    logic [DATA_W-1:0] dir;
    logic [DATA_W-1:0] fun;
    logic [WDS_W-1:0]  wd_sel;
    logic [N_HS-1:0]   hs_cfg;
    logic [DATA_W-1:0] ol;
    logic [DATA_W-1:0] ilim;
  } cfg_t;
endpackage

// File: rtl/outctl_spi_rx.sv
module outctl_spi_rx
  import outctl_pkg::*;
#(
  parameter int unsigned FW = FRAME_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sclk_i,
  input  logic          cs_ni,
  input  logic          mosi_i,
  output logic          vld_o,
  output logic [FW-1:0] word_o
);
  localparam int unsigned CNT_W = $clog2(FW + 2);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FW);
  localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(FW + 1);

  logic [1:0]       sclk_ff, cs_ff, mosi_ff;
  logic             sclk_d, cs_d;
  logic [FW-1:0]    shift_q;
  logic [CNT_W-1:0] cnt_q;

  wire sclk_rise = sclk_ff[1] & ~sclk_d;
  wire cs_fall   = cs_d & ~cs_ff[1];
  wire cs_rise   = ~cs_d & cs_ff[1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_ff <= '0;
      cs_ff   <= '1;
      mosi_ff <= '0;
      sclk_d  <= 1'b0;
      cs_d    <= 1'b1;
      shift_q <= '0;
      cnt_q   <= '0;
      vld_o   <= 1'b0;
      word_o  <= '0;
    end else begin
      sclk_ff <= {sclk_ff[0], sclk_i};
      cs_ff   <= {cs_ff[0], cs_ni};
      mosi_ff <= {mosi_ff[0], mosi_i};
      sclk_d  <= sclk_ff[1];
      cs_d    <= cs_ff[1];
      vld_o   <= 1'b0;
      if (cs_fall) begin
        cnt_q <= '0;
      end else if (!cs_ff[1] && sclk_rise) begin
        shift_q <= {shift_q[FW-2:0], mosi_ff[1]};
        if (cnt_q != CNT_SAT) cnt_q <= cnt_q + 1'b1;
      end
      if (cs_rise) begin
        if (cnt_q == CNT_FULL) begin
          vld_o  <= 1'b1;
          word_o <= shift_q;
        end
        cnt_q <= '0;
      end
    end
  end
endmodule

// File: rtl/outctl_regs.sv
module outctl_regs
  import outctl_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               vld_i,
  input  logic [FRAME_W-1:0] word_i,
  output cfg_t               cfg_o,
  output logic               frame_o,
  output logic               wd_bit_o
);
  logic [DATA_W-1:0] data;
  addr_e             addr;

  assign data = word_i[DATA_W-1:0];
  assign addr = addr_e'(word_i[ADDR_LSB +: ADDR_W]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_o     <= '0;
      cfg_o.dir <= '1;
      frame_o   <= 1'b0;
      wd_bit_o  <= 1'b0;
    end else begin
      frame_o <= vld_i;
      if (vld_i) begin
        wd_bit_o <= word_i[TOG_BIT];
        unique case (addr)
          ADR_MSG: cfg_o.msg  <= data;
          ADR_DIR: cfg_o.dir  <= data;
          ADR_FUN: cfg_o.fun  <= data;
          ADR_WDC: begin
            cfg_o.wd_sel <= data[N_HS +: WDS_W];
            cfg_o.hs_cfg <= data[N_HS-1:0];
          end
          ADR_OLC: cfg_o.ol   <= data;
          ADR_ILC: cfg_o.ilim <= data;
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/outctl_mix.sv
module outctl_mix
  import outctl_pkg::*;
#(
  parameter int unsigned NO = N_OUT,
  parameter int unsigned NH = N_HS
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [NH-1:0] dhs_i,
  input  logic          dls_i,
  input  logic [NO-1:0] msg_i,
  input  logic [NO-1:0] dir_i,
  input  logic [NO-1:0] fun_i,
  output logic [NH:0]   pin_s_o,
  output logic [NO-1:0] out_o
);
  logic [NH:0]   pin_ff1;
  logic [NO-1:0] nxt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pin_ff1 <= '0;
      pin_s_o <= '0;
    end else begin
      pin_ff1 <= {dls_i, dhs_i};
      pin_s_o <= pin_ff1;
    end
  end

  for (genvar i = 0; i < NO; i++) begin : g_ch
    logic pin;
    if (i < NH) begin : g_hs
      assign pin = pin_s_o[i];
    end else begin : g_ls
      assign pin = pin_s_o[NH];
    end
    // dir=1: pin ignored; fun=1: AND, fun=0: OR
    assign nxt[i] = dir_i[i] ? msg_i[i]
                  : (fun_i[i] ? (msg_i[i] & pin) : (msg_i[i] | pin));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) out_o <= '0;
    else         out_o <= nxt;
  end
endmodule

// File: rtl/outctl_spi.sv
module outctl_spi
  import outctl_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                sclk_i,
  input  logic                cs_ni,
  input  logic                mosi_i,
  input  logic [N_HS-1:0]     dhs_i,
  input  logic                dls_i,
  output logic [N_HS-1:0]     hs_o,
  output logic [N_OUT-N_HS-1:0] ls_o,
  output logic [WDS_W-1:0]    wd_sel_o,
  output logic [N_HS-1:0]     hs_cfg_o,
  output logic [DATA_W-1:0]   ol_cfg_o,
  output logic [DATA_W-1:0]   ilim_cfg_o,
  output logic                frame_o,
  output logic                wd_bit_o
);
  logic               rx_vld;
  logic [FRAME_W-1:0] rx_word;
  cfg_t               cfg;
  logic [N_HS:0]      pin_s;
  logic [N_OUT-1:0]   out_q;

  outctl_spi_rx #(.FW(FRAME_W)) u_rx (
    .clk_i, .rst_ni, .sclk_i, .cs_ni, .mosi_i,
    .vld_o(rx_vld), .word_o(rx_word)
  );

  outctl_regs u_regs (
    .clk_i, .rst_ni, .vld_i(rx_vld), .word_i(rx_word),
    .cfg_o(cfg), .frame_o, .wd_bit_o
  );

  outctl_mix #(.NO(N_OUT), .NH(N_HS)) u_mix (
    .clk_i, .rst_ni, .dhs_i, .dls_i,
    .msg_i(cfg.msg), .dir_i(cfg.dir), .fun_i(cfg.fun),
    .pin_s_o(pin_s), .out_o(out_q)
  );

  assign hs_o       = out_q[N_HS-1:0];
  assign ls_o       = out_q[N_OUT-1:N_HS];
  assign wd_sel_o   = cfg.wd_sel;
  assign hs_cfg_o   = cfg.hs_cfg;
  assign ol_cfg_o   = cfg.ol;
  assign ilim_cfg_o = cfg.ilim;
endmodule

// File: rtl/outctl_spi_chk.sv
module outctl_spi_chk
  import outctl_pkg::*;
(
  input logic               clk_i,
  input logic               rst_ni,
  input logic               rx_vld,
  input logic [FRAME_W-1:0] rx_word,
  input cfg_t               cfg,
  input logic [N_HS:0]      pin_s,
  input logic [N_OUT-1:0]   out_v,
  input logic               frame_o,
  input logic               wd_bit_o
);
  a_r11_one_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_o |=> !frame_o);

  a_r11_wd_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_vld |=> (frame_o && wd_bit_o == $past(rx_word[TOG_BIT])));

  a_r12_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($stable(cfg) && $stable(pin_s)) |=> $stable(out_v));

  a_r7_no_direct: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((out_v & $past(cfg.dir)) == ($past(cfg.msg) & $past(cfg.dir))));

  a_r10_dead_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_vld && (rx_word[ADDR_LSB +: ADDR_W] == ADR_NUL ||
                rx_word[ADDR_LSB +: ADDR_W] == ADR_TST)) |=> $stable(cfg));
endmodule

bind outctl_spi outctl_spi_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .rx_vld(rx_vld), .rx_word(rx_word),
  .cfg(cfg), .pin_s(pin_s), .out_v(out_q), .frame_o(frame_o),
  .wd_bit_o(wd_bit_o)
);

// File: tb/outctl_spi_tb.sv
module outctl_spi_tb;
  logic clk = 1'b0, rst_ni = 1'b0;
  logic sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic [3:0] dhs = '0;
  logic dls = 1'b0;
  logic [3:0] hs_o, hs_cfg_o;
  logic [7:0] ls_o;
  logic [1:0] wd_sel_o;
  logic [11:0] ol_cfg_o, ilim_cfg_o;
  logic frame_o, wd_bit_o;

  always #2ns clk = ~clk;

  outctl_spi u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .sclk_i(sclk), .cs_ni(cs_n), .mosi_i(mosi),
    .dhs_i(dhs), .dls_i(dls), .hs_o(hs_o), .ls_o(ls_o), .wd_sel_o(wd_sel_o),
    .hs_cfg_o(hs_cfg_o), .ol_cfg_o(ol_cfg_o), .ilim_cfg_o(ilim_cfg_o),
    .frame_o(frame_o), .wd_bit_o(wd_bit_o)
  );

  typedef struct {
    logic [46:0] vec;
    int          nfr;
    string       tag;
  } item_t;
  item_t q[$];

  int checks = 0, fails = 0, nfr_seen = 0;
  bit done = 0;

  // reference model state
  logic [11:0] m_msg = '0, m_dir = '1, m_fun = '0, m_ol = '0, m_il = '0;
  logic [1:0]  m_wds = '0;
  logic [3:0]  m_hsc = '0;
  logic        m_wdb = 1'b0, tog = 1'b1;
  int          m_nfr = 0;

  function automatic logic [11:0] model_out();
    logic [11:0] o;
    for (int i = 0; i < 12; i++) begin
      logic p;
      p = (i < 4) ? dhs[i] : dls;
      o[i] = m_dir[i] ? m_msg[i] : (m_fun[i] ? (m_msg[i] & p) : (m_msg[i] | p));
    end
    return o;
  endfunction

  function automatic logic [46:0] model_vec();
    return {model_out(), m_wds, m_hsc, m_ol, m_il, m_wdb, 4'h0};
  endfunction

  task automatic push(input string tag, input logic [46:0] v);
    item_t it;
    it.vec = v; it.nfr = m_nfr; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic expect_now(input string tag);
    push(tag, model_vec());
  endtask

  // frame pulse counter
  always @(negedge clk) if (rst_ni && frame_o) nfr_seen++;

  // monitor
  initial begin
    forever begin
      @(negedge clk); #1;
      while (q.size() > 0) begin
        item_t it;
        logic [46:0] act;
        it = q.pop_front();
        act = {ls_o, hs_o, wd_sel_o, hs_cfg_o, ol_cfg_o, ilim_cfg_o, wd_bit_o, 4'h0};
        checks++;
        if (act !== it.vec || nfr_seen != it.nfr) begin
          fails++;
          $display("FAIL %s: actual %h frames %0d, expected %h frames %0d",
                   it.tag, act, nfr_seen, it.vec, it.nfr);
        end
      end
    end
  end

  task automatic spi_xfer(input int nb, input logic [15:0] w);
    cs_n = 1'b0;
    repeat (4) @(negedge clk);
    for (int i = 0; i < nb; i++) begin
      mosi = (i < 16) ? w[15-i] : 1'b0;
      repeat (4) @(negedge clk);
      sclk = 1'b1;
      repeat (4) @(negedge clk);
      sclk = 1'b0;
    end
    repeat (4) @(negedge clk);
    cs_n = 1'b1;
    repeat (12) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [11:0] d);
    spi_xfer(16, {tog, a, d});
    m_wdb = tog;
    tog = ~tog;
    m_nfr++;
    case (a)
      3'b000: m_msg = d;
      3'b100: m_dir = d;
      3'b010: m_fun = d;
      3'b110: begin m_wds = d[5:4]; m_hsc = d[3:0]; end
      3'b001: m_ol = d;
      3'b101: m_il = d;
      default: ;
    endcase
  endtask

  task automatic set_pins(input logic [3:0] h, input logic l);
    dhs = h; dls = l;
    repeat (6) @(negedge clk);
  endtask

  task automatic finish_run();
    repeat (4) @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: run did not complete, actual hung, expected done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [46:0] old_v;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk);
    expect_now("R4 reset state");
    set_pins(4'hF, 1'b1);
    expect_now("R4 R7 pins ignored after reset");
    set_pins(4'h0, 1'b0);

    wr(3'b000, 12'hA5C);
    expect_now("R1 R3 message word, R11 toggle 1");
    wr(3'b000, 12'h001);
    expect_now("R1 lsb only, R11 toggle 0");
    wr(3'b000, 12'h800);
    expect_now("R1 R3 msb maps to ls_o[7]");

    spi_xfer(15, {1'b1, 3'b000, 12'hFFF});
    expect_now("R2 15-clock frame dropped");
    spi_xfer(17, {1'b1, 3'b000, 12'hFFF});
    expect_now("R2 17-clock frame dropped");

    wr(3'b000, 12'h0F3);
    wr(3'b100, 12'h000);
    set_pins(4'b0101, 1'b1);
    expect_now("R6 R8 OR mix pins 0101 ls 1");
    set_pins(4'b1010, 1'b0);
    expect_now("R6 R8 OR mix pins 1010 ls 0");

    wr(3'b010, 12'hFFF);
    expect_now("R5 AND mix pins 1010 ls 0");
    set_pins(4'b0111, 1'b1);
    expect_now("R5 R8 AND mix pins 0111 ls 1");

    wr(3'b100, 12'hF0A);
    wr(3'b010, 12'h00F);
    set_pins(4'b0000, 1'b1);
    expect_now("R7 partial direct mask A");
    set_pins(4'b1111, 1'b0);
    expect_now("R7 partial direct mask B");

    // latency after a pin change
    @(negedge clk);
    old_v = model_vec();
    dhs = 4'b0000; dls = 1'b1;
    @(negedge clk);
    @(negedge clk);
    push("R12 old value held two clocks", old_v);
    @(negedge clk);
    expect_now("R12 new value after third edge");
    repeat (4) @(negedge clk);

    wr(3'b110, 12'hFFF);
    expect_now("R9 watchdog cfg all ones");
    wr(3'b110, 12'hFD6);
    expect_now("R9 upper bits ignored");

    wr(3'b001, 12'h3C5);
    wr(3'b101, 12'hA69);
    expect_now("R10 open-load and current-limit words");
    wr(3'b011, 12'hFFF);
    wr(3'b111, 12'h555);
    expect_now("R10 dead addresses change nothing");

    wr(3'b100, 12'hFFF);
    wr(3'b000, 12'h000);
    expect_now("R3 R11 all off, toggle tracked");

    repeat (8) @(negedge clk);
    done = 1;
    finish_run();
  end
endmodule